// File: doc/BRIEF.md
# Digital Potentiometer Register Controller

This block holds the register state behind a single-channel digital potentiometer and sits behind a serial-interface slave. That slave hands it register requests, each with an address, a read/write flag, write data and a strobe. The block drives a 7-bit wiper position to the resistor array. It keeps a local copy of the non-volatile initial value, and it starts writes to a behavioural non-volatile storage port that reports a busy flag while it works.

Address 0 is shared. A volatility-select bit in the control register decides whether an access there reaches the volatile wiper alone or the non-volatile initial value. Writing the initial value also moves the wiper. After reset the wiper sits at mid-scale. Once the storage reports that it can be read, the stored value is recalled into the wiper, and only then does the block accept requests. A non-volatile write raises a write-in-progress flag. While that flag is set, every write is dropped. The software shutdown bit and an external pin are combined into a single shutdown output.

Top module: `dpot_regfile`

## Requirements
- R1: After reset the wiper is 40h, `req_ready` is 0, and the control register holds volatility-select 0, shutdown-control 1 and write-in-progress 0. It therefore reads 8'h40. Requests made while `req_ready` is 0 have no effect.
- R2: At the first clock edge where `nv_ready` is 1, the wiper and the initial-value copy load `nv_rd_data`. From then on `req_ready` is 1 and stays 1 until reset.
- R3: When control bit 7 (volatility-select) is 1, a write to address 0 sets the wiper to data bits 6:0 and does not raise `nv_wr_en`. A read from address 0 returns {0, wiper}.
- R4: When control bit 7 is 0, a write to address 0 raises `nv_wr_en` for that cycle with `nv_wr_data` equal to data bits 6:0. At the same edge it updates both the wiper and the initial-value copy. A read from address 0 returns {0, initial-value copy}.
- R5: An accepted non-volatile write sets write-in-progress (control bit 5) at its edge. The flag holds for at least WIP_CYCLES+1 cycles and then clears at the first edge where that window has expired and `nv_busy` is 0.
- R6: While write-in-progress is 1, writes to address 0 (in either mode) and to the control register are ignored. Reads are still served.
- R7: The control register is at address 2. Bit 7 is volatility-select and bit 6 is shutdown-control; both are writable. Bit 5 is read-only. Bits 4:0 read as 0.
- R8: Addresses 1 and 3 are reserved. Writes to them change nothing, and reads from them return 00h.
- R9: `shutdown` is 1 exactly when shutdown-control is 0 and `shdn_pin` is 0.
- R10: An accepted read gives `rsp_valid`=1 in the next cycle. `rsp_rdata` holds the register value from before that edge. In every other cycle `rsp_valid` is 0.
- R11: Bit 7 of data written to address 0 is discarded. The wiper and the initial-value copy keep only 7 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | Register address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Recall finished; requests are accepted |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 8 | Read data |
| nv_ready | input | 1 | Storage contents can be read reliably |
| nv_rd_data | input | 7 | Stored initial value |
| nv_wr_en | output | 1 | Start a non-volatile write |
| nv_wr_data | output | 7 | Value to store |
| nv_busy | input | 1 | Storage still programming |
| shdn_pin | input | 1 | External shutdown control (0 requests shutdown) |
| shutdown | output | 1 | Potentiometer in shutdown |
| wiper_pos | output | 7 | Wiper position to resistor array |

## Verification
The most delicate overlap is a write request that lands in the same cycle as the last cycle of write-in-progress. That is the cycle where the window has expired and `nv_busy` drops, and because the flag is still 1 at that edge, the write must still be dropped. The bench provokes this case, and other near-boundary cases, by holding `nv_busy` high for a random number of cycles and issuing random writes at every address throughout the window. A bench-side model of the flag then judges each result against the wiper value and the read responses. The second overlap is a read and the completion edge in the same cycle. There the read must report the flag from before the edge.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 2;
  localparam logic [ADDR_W-1:0] ADDR_POS = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTL = 2'd2;
  localparam int BIT_VOL   = 7;
  localparam int BIT_SHDN  = 6;
  localparam int BIT_WIP   = 5;

  typedef enum logic {BOOT_WAIT = 1'b0, BOOT_RUN = 1'b1} boot_state_t;
endpackage

// File: rtl/dpot_rst_sync.sv
module dpot_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/dpot_boot_seq.sv
module dpot_boot_seq
  import dpot_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic nv_ready,
  output logic load,
  output logic ready
);
  boot_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    if (state_q == BOOT_WAIT && nv_ready) begin
      state_d = BOOT_RUN;
      load    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= BOOT_WAIT;
    else        state_q <= state_d;
  end

  assign ready = (state_q == BOOT_RUN);
endmodule

// File: rtl/dpot_wip_timer.sv
module dpot_wip_timer #(
  parameter int WIP_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic nv_busy,
  output logic wip
);
  logic wip_q, wip_d;

  generate
    if (WIP_CYCLES > 0) begin : g_timed
      localparam int CW = $clog2(WIP_CYCLES + 1);
      logic [CW-1:0] cnt_q, cnt_d;

      always_comb begin
        wip_d = wip_q;
        cnt_d = cnt_q;
        if (start) begin
          wip_d = 1'b1;
          cnt_d = CW'(WIP_CYCLES);
        end else if (wip_q) begin
          if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
          else if (!nv_busy) wip_d = 1'b0;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end
    end else begin : g_untimed
      always_comb begin
        wip_d = wip_q;
        if (start)                wip_d = 1'b1;
        else if (wip_q && !nv_busy) wip_d = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wip_q <= 1'b0;
    else        wip_q <= wip_d;
  end

  assign wip = wip_q;
endmodule

// File: rtl/dpot_regfile.sv
module dpot_regfile
  import dpot_pkg::*;
#(
  parameter int WIPER_W    = 7,
  parameter int WIP_CYCLES = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               req_ready,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_rdata,
  input  logic               nv_ready,
  input  logic [WIPER_W-1:0] nv_rd_data,
  output logic               nv_wr_en,
  output logic [WIPER_W-1:0] nv_wr_data,
  input  logic               nv_busy,
  input  logic               shdn_pin,
  output logic               shutdown,
  output logic [WIPER_W-1:0] wiper_pos
);
  localparam logic [WIPER_W-1:0] MID_POS = WIPER_W'(1) << (WIPER_W - 1);
  localparam int PAD_W = DATA_W - WIPER_W;

  logic rst_n_i, boot_load, wip;
  logic accept, wr_pos, wr_ctl, nv_start;
  logic [WIPER_W-1:0] wiper_q, wiper_d, ivr_q, ivr_d;
  logic vol_q, vol_d, shdn_q, shdn_d;
  logic rsp_valid_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  dpot_rst_sync u_rst_sync (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i));

  dpot_boot_seq u_boot (
    .clk(clk), .rst_n(rst_n_i), .nv_ready(nv_ready),
    .load(boot_load), .ready(req_ready)
  );

  dpot_wip_timer #(.WIP_CYCLES(WIP_CYCLES)) u_wip (
    .clk(clk), .rst_n(rst_n_i), .start(nv_start), .nv_busy(nv_busy), .wip(wip)
  );

  // request decode
  always_comb begin
    accept   = req_valid & req_ready;
    wr_pos   = accept & req_write & (req_addr == ADDR_POS) & ~wip;
    wr_ctl   = accept & req_write & (req_addr == ADDR_CTL) & ~wip;
    nv_start = wr_pos & ~vol_q;
  end

  // next state of the register file
  always_comb begin
    wiper_d = wiper_q;
    ivr_d   = ivr_q;
    vol_d   = vol_q;
    shdn_d  = shdn_q;
    if (boot_load) begin
      wiper_d = nv_rd_data;
      ivr_d   = nv_rd_data;
    end else if (wr_pos) begin
      wiper_d = req_wdata[WIPER_W-1:0];
      if (!vol_q) ivr_d = req_wdata[WIPER_W-1:0];
    end
    if (wr_ctl) begin
      vol_d  = req_wdata[BIT_VOL];
      shdn_d = req_wdata[BIT_SHDN];
    end
  end

  // read path
  always_comb begin
    rsp_valid_d = accept & ~req_write;
    rdata_d     = '0;
    case (req_addr)
      ADDR_POS: rdata_d = {{PAD_W{1'b0}}, (vol_q ? wiper_q : ivr_q)};
      ADDR_CTL: begin
        rdata_d[BIT_VOL]  = vol_q;
        rdata_d[BIT_SHDN] = shdn_q;
        rdata_d[BIT_WIP]  = wip;
      end
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      wiper_q   <= MID_POS;
      ivr_q     <= '0;
      vol_q     <= 1'b0;
      shdn_q    <= 1'b1;
      rsp_valid <= 1'b0;
      rdata_q   <= '0;
    end else begin
      wiper_q   <= wiper_d;
      ivr_q     <= ivr_d;
      vol_q     <= vol_d;
      shdn_q    <= shdn_d;
      rsp_valid <= rsp_valid_d;
      if (rsp_valid_d) rdata_q <= rdata_d;
    end
  end

  assign rsp_rdata  = rdata_q;
  assign nv_wr_en   = nv_start;
  assign nv_wr_data = req_wdata[WIPER_W-1:0];
  assign wiper_pos  = wiper_q;
  assign shutdown   = ~(shdn_q | shdn_pin);
endmodule

// File: rtl/dpot_regfile_chk.sv
module dpot_regfile_chk #(
  parameter int WIPER_W = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_write,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic               nv_wr_en,
  input logic [WIPER_W-1:0] nv_wr_data,
  input logic               shdn_pin,
  input logic               shutdown,
  input logic [WIPER_W-1:0] wiper_pos,
  input logic               wip
);
  p_ready_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> req_ready);

  p_nv_write_loads_wiper_r4: assert property (@(posedge clk) disable iff (!rst_n)
    nv_wr_en |=> (wiper_pos == $past(nv_wr_data)));

  p_nv_write_sets_wip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    nv_wr_en |=> wip);

  p_no_nv_write_in_wip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wip |-> !nv_wr_en);

  p_wiper_frozen_in_wip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wip && req_ready) |=> $stable(wiper_pos));

  p_pin_blocks_shutdown_r9: assert property (@(posedge clk) disable iff (!rst_n)
    shdn_pin |-> !shutdown);

  p_no_rsp_unready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> !rsp_valid);

  p_rsp_after_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid);
endmodule

bind dpot_regfile dpot_regfile_chk #(.WIPER_W(WIPER_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_ready(req_ready), .rsp_valid(rsp_valid), .nv_wr_en(nv_wr_en),
  .nv_wr_data(nv_wr_data), .shdn_pin(shdn_pin), .shutdown(shutdown),
  .wiper_pos(wiper_pos), .wip(wip)
);

// File: tb/dpot_regfile_bench.sv
`timescale 1ns/1ps
module dpot_regfile_bench;
  localparam int WIPC = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_write;
  logic [1:0] req_addr;
  logic [7:0] req_wdata;
  logic req_ready, rsp_valid;
  logic [7:0] rsp_rdata;
  logic nv_ready;
  logic [6:0] nv_rd_data;
  logic nv_wr_en;
  logic [6:0] nv_wr_data;
  logic nv_busy, shdn_pin, shutdown;
  logic [6:0] wiper_pos;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // reference model state
  logic [6:0] m_wiper, m_ivr;
  logic m_vol, m_shdn, m_wip, m_ready;
  int m_cnt;

  dpot_regfile #(.WIPER_W(7), .WIP_CYCLES(WIPC)) u_dpot_regfile (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .nv_ready(nv_ready),
    .nv_rd_data(nv_rd_data), .nv_wr_en(nv_wr_en), .nv_wr_data(nv_wr_data),
    .nv_busy(nv_busy), .shdn_pin(shdn_pin), .shutdown(shutdown),
    .wiper_pos(wiper_pos)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model_read(input logic [1:0] a);
    case (a)
      2'd0:    return {1'b0, (m_vol ? m_wiper : m_ivr)};
      2'd2:    return {m_vol, m_shdn, m_wip, 5'b0};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic model_nvwr(input logic v, input logic w, input logic [1:0] a);
    return v && m_ready && w && (a == 2'd0) && !m_vol && !m_wip;
  endfunction

  // one request cycle: drive, check the combinational write strobe, clock, update model, check outputs
  task automatic step(input logic v, input logic w, input logic [1:0] a,
                      input logic [7:0] d, input logic busy);
    logic exp_rv, exp_nv, acc;
    logic [7:0] exp_rd;
    @(negedge clk);
    req_valid = v; req_write = w; req_addr = a; req_wdata = d; nv_busy = busy;
    #1;
    exp_nv = model_nvwr(v, w, a);
    chk("R4 nv_wr_en", {7'b0, nv_wr_en}, {7'b0, exp_nv});
    if (exp_nv) chk("R4 nv_wr_data", {1'b0, nv_wr_data}, {1'b0, d[6:0]});
    @(posedge clk);
    acc    = v && m_ready;
    exp_rv = acc && !w;
    exp_rd = model_read(a);
    if (m_wip) begin
      if (m_cnt != 0) m_cnt = m_cnt - 1;
      else if (!busy) m_wip = 1'b0;
    end
    if (acc && w && !m_wip_prev_guard()) begin end
    if (!m_ready && nv_ready) begin
      m_wiper = nv_rd_data; m_ivr = nv_rd_data; m_ready = 1'b1;
    end
    #1;
    chk("R3 wiper_pos", {1'b0, wiper_pos}, {1'b0, m_wiper});
    chk("R2 req_ready", {7'b0, req_ready}, {7'b0, m_ready});
    chk("R9 shutdown", {7'b0, shutdown}, {7'b0, (!m_shdn && !shdn_pin)});
    chk("R10 rsp_valid", {7'b0, rsp_valid}, {7'b0, exp_rv});
    if (exp_rv) chk("R10 rsp_rdata", rsp_rdata, exp_rd);
  endtask

  // write side of the model, applied with the pre-edge flag value
  logic pend_v, pend_w, pend_wip;
  logic [1:0] pend_a;
  logic [7:0] pend_d;
  function automatic logic m_wip_prev_guard();
    if (pend_v && m_ready && pend_w && !pend_wip) begin
      if (pend_a == 2'd0) begin
        m_wiper = pend_d[6:0];
        if (!m_vol) begin
          m_ivr = pend_d[6:0];
          m_wip = 1'b1;
          m_cnt = WIPC;
        end
      end else if (pend_a == 2'd2) begin
        m_vol  = pend_d[7];
        m_shdn = pend_d[6];
      end
    end
    return 1'b1;
  endfunction

  task automatic op(input logic v, input logic w, input logic [1:0] a,
                    input logic [7:0] d, input logic busy);
    pend_v = v; pend_w = w; pend_a = a; pend_d = d; pend_wip = m_wip;
    step(v, w, a, d, busy);
  endtask

  task automatic rd_expect(input string tag, input logic [1:0] a, input logic [7:0] exp);
    op(1'b1, 1'b0, a, 8'h00, 1'b0);
    chk(tag, rsp_rdata, exp);
  endtask

  initial begin
    int wip_seen;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0;
    nv_ready = 0; nv_rd_data = 7'h15; nv_busy = 0; shdn_pin = 0;
    m_wiper = 7'h40; m_ivr = 7'h00; m_vol = 0; m_shdn = 1; m_wip = 0; m_ready = 0; m_cnt = 0;
    pend_v = 0; pend_w = 0; pend_a = 0; pend_d = 0; pend_wip = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state and requests ignored before recall
    #1;
    chk("R1 wiper reset", {1'b0, wiper_pos}, 8'h40);
    chk("R1 ready low", {7'b0, req_ready}, 8'h00);
    chk("R1 shutdown off", {7'b0, shutdown}, 8'h00);
    repeat (4) op(1'b1, 1'b1, 2'd0, 8'h7f, 1'b0);
    op(1'b1, 1'b1, 2'd2, 8'h00, 1'b0);
    chk("R1 early write ignored", {1'b0, wiper_pos}, 8'h40);
    // R2: recall
    nv_ready = 1'b1;
    op(1'b0, 1'b0, 2'd0, 8'h00, 1'b0);
    chk("R2 recall", {1'b0, wiper_pos}, 8'h15);
    rd_expect("R1 ctl reset value", 2'd2, 8'h40);
    rd_expect("R4 ivr read", 2'd0, 8'h15);
    // R3: volatile-only access
    op(1'b1, 1'b1, 2'd2, 8'hc0, 1'b0);
    op(1'b1, 1'b1, 2'd0, 8'hff, 1'b0);
    chk("R11 bit7 dropped", {1'b0, wiper_pos}, 8'h7f);
    rd_expect("R3 wiper read", 2'd0, 8'h7f);
    op(1'b1, 1'b1, 2'd2, 8'h40, 1'b0);
    rd_expect("R3 ivr untouched", 2'd0, 8'h15);
    // R7: low control bits
    op(1'b1, 1'b1, 2'd2, 8'h5f, 1'b0);
    rd_expect("R7 low bits zero", 2'd2, 8'h40);
    // R8: reserved addresses
    op(1'b1, 1'b1, 2'd1, 8'haa, 1'b0);
    op(1'b1, 1'b1, 2'd3, 8'h55, 1'b0);
    rd_expect("R8 reserved 1", 2'd1, 8'h00);
    rd_expect("R8 reserved 3", 2'd3, 8'h00);
    chk("R8 wiper kept", {1'b0, wiper_pos}, 8'h7f);
    // R9: shutdown combination
    op(1'b1, 1'b1, 2'd2, 8'h00, 1'b0);
    chk("R9 both low", {7'b0, shutdown}, 8'h01);
    shdn_pin = 1'b1; #1;
    chk("R9 pin high", {7'b0, shutdown}, 8'h00);
    shdn_pin = 1'b0;
    op(1'b1, 1'b1, 2'd2, 8'h40, 1'b0);
    // R4/R5/R6: non-volatile write and lockout
    op(1'b1, 1'b1, 2'd0, 8'h9a, 1'b0);
    chk("R4 wiper follows", {1'b0, wiper_pos}, 8'h1a);
    op(1'b1, 1'b1, 2'd0, 8'h33, 1'b0);
    chk("R6 write dropped", {1'b0, wiper_pos}, 8'h1a);
    op(1'b1, 1'b1, 2'd2, 8'hc0, 1'b0);
    wip_seen = 2;
    while (wip_seen < 60) begin
      op(1'b1, 1'b0, 2'd2, 8'h00, 1'b0);
      if (rsp_rdata[5] == 1'b0) break;
      wip_seen = wip_seen + 1;
    end
    chk("R5 wip length", 8'(wip_seen), 8'(WIPC + 1));
    rd_expect("R6 ctl unchanged", 2'd2, 8'h40);
    // R5: busy storage extends the flag
    op(1'b1, 1'b1, 2'd0, 8'h05, 1'b0);
    for (int i = 0; i < WIPC + 6; i++) op(1'b0, 1'b0, 2'd0, 8'h00, 1'b1);
    rd_expect("R5 held by busy", 2'd2, 8'h60);
    op(1'b1, 1'b0, 2'd2, 8'h00, 1'b0);
    rd_expect("R5 cleared", 2'd2, 8'h40);
    // random phase, model judges every cycle
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] a;
      if (($urandom % 16) == 0) shdn_pin = $urandom;
      a = $urandom;
      op(($urandom % 4) != 0, $urandom, a, 8'($urandom), ($urandom % 3) == 0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule